// File: doc/BRIEF.md
# Fault Response Retry Sequencer

This block sits in a power converter controller and decides, from six already-qualified fault levels, when power conversion must be held off and when it may start again. The six fault classes are input undervoltage, input overvoltage, output overvoltage, output overcurrent, fast short-circuit and overtemperature. Each class runs its own small state machine with the states CH_IDLE, CH_FIRST, CH_STEP and CH_LATCHED. The transitions are: *declare* (CH_IDLE to CH_FIRST, or to CH_LATCHED when latching is chosen), *poll* (CH_FIRST or CH_STEP to CH_STEP when the condition is still present at expiry), *release* (CH_FIRST or CH_STEP to CH_IDLE) and *unlatch* (CH_LATCHED to CH_IDLE). Every delay is counted in ticks of a single-cycle 1 ms strobe, so a bench can scale time down.

The inhibit output is high while any class is outside CH_IDLE. Conversion may therefore resume only when every overlapping fault has been released. The output overvoltage level first passes through an up/down event filter with a programmable threshold, and that threshold sets the response delay. Sticky per-class status bits record every declaration until a clear pulse arrives. A latched output overvoltage clears only on a power cycle, which is the reset. Latched overcurrent, short-circuit and overtemperature faults also clear when the run command is switched off.

Top module: `fault_retry_seq`

## Requirements
- R1: After reset `inhibit` is 0 and `status` is all zeros.
- R2: An input undervoltage is always retried. It waits UV_FIRST_MS ticks. At expiry, if `vin_low` is still high, it waits STEP_MS more ticks and checks again, repeating until the check finds the input low, and then releases.
- R3: An input overvoltage is always retried with a first wait of OVIN_FIRST_MS ticks, followed by STEP_MS-tick rechecks of `vin_high` until it is low.
- R4: Overtemperature latches when `latch_sel[3]`=1. Otherwise it waits OT_FIRST_MS ticks and then STEP_MS-tick rechecks. Each recheck tests `hot_above_clr` (the hysteresis clear level), not `hot_trip`.
- R5: Output overvoltage latches when `latch_sel[0]`=1. Otherwise it waits OVP_RETRY_MS ticks and releases without a recheck.
- R6: Overcurrent latches when `latch_sel[1]`=1. Otherwise it waits `ocp_retry_ms` ticks, sampled at declaration, with a value of 0 treated as 1, and then releases.
- R7: Short-circuit latches when `latch_sel[2]`=1. Otherwise it waits SC_RETRY_MS ticks and then releases.
- R8: A high-to-low transition of `run_en` releases latched overcurrent, short-circuit and overtemperature faults. It has no effect on a latched output overvoltage, which only reset releases.
- R9: The output overvoltage filter is a saturating up/down counter that steps once per clock: up while `vout_high_raw` is 1, down while it is 0. The fault is declared when the count reaches `ovp_count_n` (0 acts as 1). The counter is held at zero while that class is busy.
- R10: A class declares when it is in CH_IDLE and its fault level is sampled high. `inhibit` rises after that same edge and falls only when all six classes are back in CH_IDLE.
- R11: `status` bits are 0 undervoltage, 1 input overvoltage, 2 output overvoltage, 3 overcurrent, 4 short-circuit, 5 overtemperature. A bit is set on declaration and stays set after release until `clear_faults`. If a declaration and a clear fall in the same cycle, the set wins.
- R12: Retry timers move only on clocks where `tick_1ms` is 1. A wait of D ticks releases or rechecks on the D-th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power cycle) |
| tick_1ms | input | 1 | Single-cycle timebase strobe |
| vin_low | input | 1 | Input undervoltage level |
| vin_high | input | 1 | Input overvoltage level |
| vout_high_raw | input | 1 | Unfiltered output overvoltage level |
| iout_high | input | 1 | Overcurrent level |
| short_det | input | 1 | Short-circuit level |
| hot_trip | input | 1 | Overtemperature trip level |
| hot_above_clr | input | 1 | Temperature above clear (hysteresis) level |
| latch_sel | input | 4 | Latch select: bit0 output OV, bit1 overcurrent, bit2 short, bit3 overtemperature |
| run_en | input | 1 | On/off command; its falling edge unlatches |
| ocp_retry_ms | input | TW | Overcurrent retry delay in ticks |
| ovp_count_n | input | CW | Output overvoltage event threshold |
| clear_faults | input | 1 | Clears the sticky status |
| inhibit | output | 1 | Conversion inhibit |
| status | output | 6 | Sticky per-class fault flags |

## Verification
The bench builds the block with UV_FIRST_MS=4, STEP_MS=3, OVIN_FIRST_MS=6, OT_FIRST_MS=8, OVP_RETRY_MS=10 and SC_RETRY_MS=5, with a tick every third clock. With these values every first wait, several rounds of 50 ms-style polling and each latch path are reached within a few hundred cycles. It also uses an event threshold of 3 and overcurrent delays of 7 and 0, which exercise the filter's partial up/down runs and the zero-delay corner. Pausing the tick while a fault is pending shows that the timers hold their count.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int NCLS = 6;

    localparam int CLS_VIN_LOW  = 0;
    localparam int CLS_VIN_HIGH = 1;
    localparam int CLS_VOUT_OV  = 2;
    localparam int CLS_IOUT_OC  = 3;
    localparam int CLS_SHORT    = 4;
    localparam int CLS_HOT      = 5;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_FIRST   = 2'd1,
        CH_STEP    = 2'd2,
        CH_LATCHED = 2'd3
    } ch_state_t;

endpackage

// File: rtl/fr_ovp_filter.sv
module fr_ovp_filter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic          hold_clr,
    input  logic [CW-1:0] need,
    output logic          trip
);
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] need_eff;

    assign need_eff = (need == '0) ? ONE : need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold_clr) begin
            cnt <= '0;
        end else if (raw && cnt != CMAX) begin
            cnt <= cnt + ONE;
        end else if (!raw && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign trip = (cnt >= need_eff);

    // R9
    filt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_clr && raw && cnt != CMAX) |=> (cnt == $past(cnt) + ONE));

    // R9
    filt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (cnt == '0));

endmodule

// File: rtl/fr_channel.sv
module fr_channel
    import fr_pkg::*;
#(
    parameter int TW         = 16,
    parameter bit RECHECK    = 1'b0,
    parameter bit LATCHABLE  = 1'b0,
    parameter bit TOGGLE_CLR = 1'b0,
    parameter int STEP       = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          trip,
    input  logic          still,
    input  logic          latch_en,
    input  logic          toggle_clr,
    input  logic [TW-1:0] first_dly,
    output logic          busy,
    output logic          declare
);
    localparam int            STEP_EFF = (STEP < 1) ? 1 : STEP;
    localparam logic [TW-1:0] STEP_V   = TW'(STEP_EFF);
    localparam logic [TW-1:0] ONE      = TW'(1);

    ch_state_t     state, nxt;
    logic [TW-1:0] cnt, cnt_nxt;
    logic [TW-1:0] first_eff;

    assign first_eff = (first_dly == '0) ? ONE : first_dly;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            CH_IDLE: begin
                if (trip) begin
                    if (LATCHABLE && latch_en) begin
                        nxt = CH_LATCHED;
                    end else begin
                        nxt     = CH_FIRST;
                        cnt_nxt = first_eff;
                    end
                end
            end
            CH_FIRST, CH_STEP: begin
                if (tick) begin
                    if (cnt <= ONE) begin
                        if (RECHECK && still) begin
                            nxt     = CH_STEP;
                            cnt_nxt = STEP_V;
                        end else begin
                            nxt     = CH_IDLE;
                            cnt_nxt = '0;
                        end
                    end else begin
                        cnt_nxt = cnt - ONE;
                    end
                end
            end
            CH_LATCHED: begin
                if (TOGGLE_CLR && toggle_clr) begin
                    nxt = CH_IDLE;
                end
            end
            default: begin
                nxt     = CH_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        busy    = (state != CH_IDLE);
        declare = (state == CH_IDLE) && trip;
    end

    // R12
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CH_FIRST || state == CH_STEP) && !tick) |=> ($stable(cnt) && $stable(state)));

    // R8
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_LATCHED && !(TOGGLE_CLR && toggle_clr)) |=> (state == CH_LATCHED));

    // R10
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && !trip) |=> (state == CH_IDLE));

endmodule

// File: rtl/fault_retry_seq.sv
module fault_retry_seq
    import fr_pkg::*;
#(
    parameter int TW            = 16,
    parameter int CW            = 8,
    parameter int UV_FIRST_MS   = 50,
    parameter int STEP_MS       = 50,
    parameter int OVIN_FIRST_MS = 250,
    parameter int OT_FIRST_MS   = 500,
    parameter int OVP_RETRY_MS  = 2000,
    parameter int SC_RETRY_MS   = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1ms,
    input  logic          vin_low,
    input  logic          vin_high,
    input  logic          vout_high_raw,
    input  logic          iout_high,
    input  logic          short_det,
    input  logic          hot_trip,
    input  logic          hot_above_clr,
    input  logic [3:0]    latch_sel,
    input  logic          run_en,
    input  logic [TW-1:0] ocp_retry_ms,
    input  logic [CW-1:0] ovp_count_n,
    input  logic          clear_faults,
    output logic          inhibit,
    output logic [5:0]    status
);
    localparam logic [NCLS-1:0] RECHECK_M = 6'b100011;
    localparam logic [NCLS-1:0] LATCH_M   = 6'b111100;
    localparam logic [NCLS-1:0] TOGGLE_M  = 6'b111000;

    logic [NCLS-1:0]         trip_v, still_v, latch_v, busy_v, decl_v;
    logic [NCLS-1:0][TW-1:0] first_dly;
    logic                    ovp_trip;
    logic                    run_q;
    logic                    run_fall;

    fr_ovp_filter #(.CW(CW)) u_ovp_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (vout_high_raw),
        .hold_clr (busy_v[CLS_VOUT_OV]),
        .need     (ovp_count_n),
        .trip     (ovp_trip)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_en;
    end
    assign run_fall = run_q && !run_en;

    always_comb begin
        trip_v  = {hot_trip, short_det, iout_high, ovp_trip, vin_high, vin_low};
        still_v = {hot_above_clr, short_det, iout_high, ovp_trip, vin_high, vin_low};
        latch_v = {latch_sel, 2'b00};
        first_dly[CLS_VIN_LOW]  = TW'(UV_FIRST_MS);
        first_dly[CLS_VIN_HIGH] = TW'(OVIN_FIRST_MS);
        first_dly[CLS_VOUT_OV]  = TW'(OVP_RETRY_MS);
        first_dly[CLS_IOUT_OC]  = ocp_retry_ms;
        first_dly[CLS_SHORT]    = TW'(SC_RETRY_MS);
        first_dly[CLS_HOT]      = TW'(OT_FIRST_MS);
    end

    for (genvar g = 0; g < NCLS; g++) begin : g_ch
        fr_channel #(
            .TW         (TW),
            .RECHECK    (RECHECK_M[g]),
            .LATCHABLE  (LATCH_M[g]),
            .TOGGLE_CLR (TOGGLE_M[g]),
            .STEP       (STEP_MS)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick_1ms),
            .trip       (trip_v[g]),
            .still      (still_v[g]),
            .latch_en   (latch_v[g]),
            .toggle_clr (run_fall),
            .first_dly  (first_dly[g]),
            .busy       (busy_v[g]),
            .declare    (decl_v[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (clear_faults ? 6'b0 : status) | decl_v;
    end

    assign inhibit = |busy_v;

    // R11
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(clear_faults));

    // R10
    inhibit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|decl_v) |=> inhibit);

endmodule

// File: tb/fault_retry_seq_test.sv
`timescale 1ns/1ps
module fault_retry_seq_test;
    localparam int TW = 16, CW = 8;
    localparam int P_UV = 4, P_STEP = 3, P_OVIN = 6, P_OT = 8, P_OVP = 10, P_SC = 5;
    localparam int TDIV = 3;

    logic clk = 1'b0, rst_n = 1'b0, tick_1ms = 1'b0;
    logic vin_low = 0, vin_high = 0, vout_high_raw = 0, iout_high = 0, short_det = 0;
    logic hot_trip = 0, hot_above_clr = 0, run_en = 1'b1, clear_faults = 0;
    logic [3:0] latch_sel = 4'b0;
    logic [TW-1:0] ocp_retry_ms = 16'd7;
    logic [CW-1:0] ovp_count_n = 8'd3;
    logic inhibit;
    logic [5:0] status;

    fault_retry_seq #(.TW(TW), .CW(CW), .UV_FIRST_MS(P_UV), .STEP_MS(P_STEP),
        .OVIN_FIRST_MS(P_OVIN), .OT_FIRST_MS(P_OT), .OVP_RETRY_MS(P_OVP),
        .SC_RETRY_MS(P_SC)) uut (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cycles = 0, tdiv = 0;
    bit tick_en = 1'b1;
    string cur_req = "R1";

    // tick generator
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TDIV;
        tick_1ms = tick_en && (tdiv == 0);
    end

    // behavioural reference model
    int m_st [6];
    int m_cnt [6];
    bit [5:0] m_status;
    int m_ovc;
    bit m_prev;
    bit [5:0] trp, stl;
    bit fall;
    int need;

    function automatic int first_of(int c);
        case (c)
            0: return P_UV;
            1: return P_OVIN;
            2: return P_OVP;
            3: return (ocp_retry_ms == 0) ? 1 : int'(ocp_retry_ms);
            4: return P_SC;
            default: return P_OT;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 6; c++) begin m_st[c] = 0; m_cnt[c] = 0; end
            m_status = '0; m_ovc = 0; m_prev = 0;
        end else begin
            need = (ovp_count_n == 0) ? 1 : int'(ovp_count_n);
            trp = {hot_trip, short_det, iout_high, (m_ovc >= need), vin_high, vin_low};
            stl = {hot_above_clr, short_det, iout_high, (m_ovc >= need), vin_high, vin_low};
            fall = m_prev && !run_en;
            m_prev = run_en;
            if (m_st[2] != 0) m_ovc = 0;
            else if (vout_high_raw) m_ovc = (m_ovc < 255) ? m_ovc + 1 : 255;
            else if (m_ovc > 0) m_ovc = m_ovc - 1;
            if (clear_faults) m_status = '0;
            for (int c = 0; c < 6; c++) begin
                case (m_st[c])
                    0: if (trp[c]) begin
                        m_status[c] = 1'b1;
                        if (c >= 2 && latch_sel[c-2]) m_st[c] = 3;
                        else begin m_st[c] = 1; m_cnt[c] = first_of(c); end
                    end
                    1, 2: if (tick_1ms) begin
                        if (m_cnt[c] <= 1) begin
                            if ((c == 0 || c == 1 || c == 5) && stl[c]) begin
                                m_st[c] = 2; m_cnt[c] = P_STEP;
                            end else m_st[c] = 0;
                        end else m_cnt[c] = m_cnt[c] - 1;
                    end
                    default: if (c >= 3 && fall) m_st[c] = 0;
                endcase
            end
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        bit exp_inh;
        cycles++;
        if (rst_n) begin
            exp_inh = 0;
            for (int c = 0; c < 6; c++) if (m_st[c] != 0) exp_inh = 1;
            n_chk++;
            if (inhibit !== exp_inh || status !== m_status) begin
                n_fail++;
                $display("FAIL %s cycle %0d: inhibit=%0b status=%b expected inhibit=%0b status=%b",
                         cur_req, cycles, inhibit, status, exp_inh, m_status);
            end
        end
    end

    task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        clear_faults = 1'b1; cyc(1); clear_faults = 1'b0; cyc(1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3); rst_n = 1'b1; cyc(1);
        cur_req = "R1";
        chk("R1", {inhibit, status}, 7'b0);

        // R2 / R12: short undervoltage, then a long one spanning rechecks
        cur_req = "R2";
        vin_low = 1; cyc(1); vin_low = 0; cyc(2);
        chk("R2", {6'b0, inhibit}, 7'b1);
        cyc(40);
        chk("R2", {6'b0, inhibit}, 7'b0);
        vin_low = 1; cyc(30); vin_low = 0; cyc(40);
        chk("R2", {inhibit, status}, 7'b0000001);
        clr();

        // R3
        cur_req = "R3";
        vin_high = 1; cyc(35); vin_high = 0; cyc(50);
        chk("R3", {inhibit, status}, 7'b0000010);
        clr();

        // R4: retry using hysteresis level, then latch
        cur_req = "R4";
        hot_trip = 1; hot_above_clr = 1; cyc(2); hot_trip = 0; cyc(40);
        chk("R4", {6'b0, inhibit}, 7'b1);
        hot_above_clr = 0; cyc(30);
        chk("R4", {inhibit, status}, 7'b0100000);
        clr();
        latch_sel = 4'b1000; hot_trip = 1; cyc(2); hot_trip = 0; cyc(80);
        chk("R4", {6'b0, inhibit}, 7'b1);
        cur_req = "R8";
        run_en = 0; cyc(2); run_en = 1; cyc(2);
        chk("R8", {6'b0, inhibit}, 7'b0);
        latch_sel = 4'b0; clr();

        // R9 / R5: filter partial runs then retry
        cur_req = "R9";
        vout_high_raw = 1; cyc(2); vout_high_raw = 0; cyc(1);
        vout_high_raw = 1; cyc(1); vout_high_raw = 0; cyc(6);
        chk("R9", {inhibit, status}, 7'b0);
        cur_req = "R5";
        vout_high_raw = 1; cyc(6); vout_high_raw = 0;
        chk("R5", {6'b0, inhibit}, 7'b1);
        cyc(60);
        chk("R5", {inhibit, status}, 7'b0000100);
        clr();
        cur_req = "R9";
        ovp_count_n = 0; vout_high_raw = 1; cyc(1); vout_high_raw = 0; cyc(50);
        ovp_count_n = 3; clr();

        // R8: output OV latch ignores run_en toggle, clears on reset
        cur_req = "R8";
        latch_sel = 4'b0001; vout_high_raw = 1; cyc(5); vout_high_raw = 0; cyc(4);
        run_en = 0; cyc(2); run_en = 1; cyc(100);
        chk("R8", {6'b0, inhibit}, 7'b1);
        rst_n = 0; cyc(2); rst_n = 1; cyc(2);
        chk("R8", {inhibit, status}, 7'b0);
        latch_sel = 4'b0;

        // R6: programmable delay, zero corner, latch
        cur_req = "R6";
        ocp_retry_ms = 7; iout_high = 1; cyc(1); iout_high = 0; cyc(40);
        ocp_retry_ms = 0; iout_high = 1; cyc(1); iout_high = 0; cyc(10);
        chk("R6", {inhibit, status}, 7'b0001000);
        latch_sel = 4'b0010; iout_high = 1; cyc(1); iout_high = 0; cyc(30);
        chk("R6", {6'b0, inhibit}, 7'b1);
        run_en = 0; cyc(1); run_en = 1; cyc(2);
        latch_sel = 4'b0; ocp_retry_ms = 7; clr();

        // R7
        cur_req = "R7";
        short_det = 1; cyc(20); short_det = 0; cyc(25);
        latch_sel = 4'b0100; short_det = 1; cyc(1); short_det = 0; cyc(30);
        chk("R7", {6'b0, inhibit}, 7'b1);
        run_en = 0; cyc(1); run_en = 1; cyc(2);
        chk("R7", {6'b0, inhibit}, 7'b0);
        latch_sel = 4'b0; clr();

        // R10: overlapping faults
        cur_req = "R10";
        vin_low = 1; short_det = 1; cyc(1); short_det = 0; cyc(20);
        chk("R10", {6'b0, inhibit}, 7'b1);
        vin_low = 0; cyc(30);
        chk("R10", {inhibit, status}, 7'b0010001);

        // R11: clear and same-cycle set
        cur_req = "R11";
        clear_faults = 1; iout_high = 1; cyc(1); clear_faults = 0; iout_high = 0; cyc(1);
        chk("R11", {1'b0, status}, 7'b0001000);
        cyc(40); clr();
        chk("R11", {1'b0, status}, 7'b0);

        // R12: paused timebase holds the wait
        cur_req = "R12";
        tick_en = 0; vin_high = 1; cyc(1); vin_high = 0; cyc(60);
        chk("R12", {6'b0, inhibit}, 7'b1);
        tick_en = 1; cyc(30);
        chk("R12", {6'b0, inhibit}, 7'b0);

        finish_run();
    end
endmodule